// File: doc/BRIEF.md
# Receive Character FIFO with Frame Length Queue

This block is the receive-side buffer of one serial channel. The receiver pushes each deserialised character into it together with a small status word. At the close of each frame, the receiver also pushes that frame's byte count into a short separate queue. The host or a DMA engine drains characters from the main queue and, on its own schedule, drains frame lengths from the length queue. Each character keeps its own status all the way through, so per-character error flags stay aligned with their data.

Two independent fill thresholds turn the main queue's occupancy into a DMA request and an interrupt request. The interrupt request is also raised while any completed frame length is waiting. Writes into a full queue are dropped and recorded in sticky overrun flags. A read from an empty queue returns zero and flags an underflow. A purge input empties everything in one clock.

Top module: `rx_frame_fifo`

## Requirements
- R1: Characters leave in the order they were written, and each `rd_stat` value is the `wr_stat` given with that same character.
- R2: The main queue holds DEPTH (32) entries. A write while `level` equals DEPTH is discarded, leaves `level` at DEPTH and sets `char_ovr`. That flag stays set until purge or reset.
- R3: A read while `level` is 0 drives `rd_char` and `rd_stat` to zero and `rd_uf` to 1, and leaves `level` at 0. A successful read drives `rd_uf` to 0.
- R4: `dma_req` is 1 exactly when `level` is nonzero and `level >= dma_thresh`. It changes on the same edge as `level`.
- R5: `irq_req` is 1 exactly when `len_level` is nonzero, or when `level` is nonzero and `level >= irq_thresh`. It changes on the same edge as the levels.
- R6: The length queue holds 4 entries and returns them in push order. A push while it is full is discarded and sets sticky `len_ovr`. A pop while it is empty returns 0 on `len_out` and sets `len_uf` to 1.
- R7: `purge` empties both queues, clears `char_ovr`, `len_ovr`, `dma_req` and `irq_req` in one clock, and wins over a write in the same cycle.
- R8: After reset, `level`, `len_level`, every flag, every request and every read output are 0.
- R9: Read results appear the cycle after the read strobe and hold until the next read strobe.
- R10: A write and a read in the same cycle on a queue that is neither empty nor full leave `level` unchanged and return the oldest character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| purge | input | 1 | Empty both queues and clear flags |
| wr_en | input | 1 | Push one character |
| wr_char | input | 8 | Character to push |
| wr_stat | input | 4 | Status bits stored with the character |
| eof_en | input | 1 | Push one frame length |
| eof_len | input | 16 | Byte count of the completed frame |
| rd_en | input | 1 | Pop one character |
| rd_char | output | 8 | Popped character (0 on underflow) |
| rd_stat | output | 4 | Status of the popped character |
| rd_uf | output | 1 | Last character read found the queue empty |
| len_rd_en | input | 1 | Pop one frame length |
| len_out | output | 16 | Popped frame length (0 on underflow) |
| len_uf | output | 1 | Last length read found the queue empty |
| dma_thresh | input | 6 | Fill level that raises the DMA request |
| irq_thresh | input | 6 | Fill level that raises the interrupt request |
| level | output | 6 | Characters held |
| len_level | output | 3 | Frame lengths held |
| dma_req | output | 1 | DMA service request |
| irq_req | output | 1 | Interrupt request |
| char_ovr | output | 1 | Sticky main-queue overrun |
| len_ovr | output | 1 | Sticky length-queue overrun |

## Verification
A corrupted pointer or count shows up at the ports at the first read after the fault. The character or status comes out of order or wrong, or `level` moves by the wrong step on the edge after a strobe. A wrong occupancy also moves `dma_req` or `irq_req` against its threshold on that same edge, so the threshold crossings are checked at the exact write that crosses them. A lost discard on overflow surfaces as a foreign character at the tail of a full drain.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W_DEF  = 8;
  localparam int STAT_W_DEF  = 4;
  localparam int DEPTH_DEF   = 32;
  localparam int FRAMES_DEF  = 4;
  localparam int LEN_W_DEF   = 16;

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         uf,
  output logic                         ovr,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !clr && !full;
  assign pop_ok  = pop  && !clr && !empty;

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (clr) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push_ok) wp <= wp + 1'b1;
        if (pop_ok)  rp <= rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      uf   <= 1'b0;
    end else if (pop && !clr) begin
      dout <= empty ? '0 : mem[rp];
      uf   <= empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          ovr <= 1'b0;
    else if (push && full)   ovr <= 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R2
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr);
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !clr && cnt == '0) |=> (cnt == '0 && uf && dout == '0));
  // R7
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !ovr));
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] lvl_nxt,
  input  logic [LW-1:0] thr,
  input  logic          force_req,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= force_req || ((lvl_nxt != '0) && (lvl_nxt >= thr));
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int CHAR_W = rxq_pkg::CHAR_W_DEF,
  parameter int STAT_W = rxq_pkg::STAT_W_DEF,
  parameter int DEPTH  = rxq_pkg::DEPTH_DEF,
  parameter int FRAMES = rxq_pkg::FRAMES_DEF,
  parameter int LEN_W  = rxq_pkg::LEN_W_DEF,
  parameter int LVL_W  = rxq_pkg::cnt_bits(DEPTH),
  parameter int FLV_W  = rxq_pkg::cnt_bits(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              purge,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              eof_en,
  input  logic [LEN_W-1:0]  eof_len,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_char,
  output logic [STAT_W-1:0] rd_stat,
  output logic              rd_uf,
  input  logic              len_rd_en,
  output logic [LEN_W-1:0]  len_out,
  output logic              len_uf,
  input  logic [LVL_W-1:0]  dma_thresh,
  input  logic [LVL_W-1:0]  irq_thresh,
  output logic [LVL_W-1:0]  level,
  output logic [FLV_W-1:0]  len_level,
  output logic              dma_req,
  output logic              irq_req,
  output logic              char_ovr,
  output logic              len_ovr
);
  localparam int ENT_W = CHAR_W + STAT_W;

  logic [ENT_W-1:0] ent_out;
  logic [LVL_W-1:0] lvl_nxt;
  logic [FLV_W-1:0] flv_nxt;

  rxq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_chars (
    .clk(clk), .rst(rst), .clr(purge),
    .push(wr_en), .din({wr_stat, wr_char}),
    .pop(rd_en), .dout(ent_out), .uf(rd_uf), .ovr(char_ovr),
    .cnt(level), .cnt_nxt(lvl_nxt)
  );

  assign rd_char = ent_out[CHAR_W-1:0];
  assign rd_stat = ent_out[ENT_W-1:CHAR_W];

  rxq_fifo #(.W(LEN_W), .DEPTH(FRAMES)) u_lens (
    .clk(clk), .rst(rst), .clr(purge),
    .push(eof_en), .din(eof_len),
    .pop(len_rd_en), .dout(len_out), .uf(len_uf), .ovr(len_ovr),
    .cnt(len_level), .cnt_nxt(flv_nxt)
  );

  rxq_thresh #(.LW(LVL_W)) u_dma (
    .clk(clk), .rst(rst), .lvl_nxt(lvl_nxt), .thr(dma_thresh),
    .force_req(1'b0), .req(dma_req)
  );

  rxq_thresh #(.LW(LVL_W)) u_irq (
    .clk(clk), .rst(rst), .lvl_nxt(lvl_nxt), .thr(irq_thresh),
    .force_req(flv_nxt != '0), .req(irq_req)
  );

  // R4
  dma_level_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (level != '0 && level >= $past(dma_thresh)));
  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (len_level != '0 || (level != '0 && level >= $past(irq_thresh))));
  // R7
  purge_req_chk: assert property (@(posedge clk) disable iff (rst)
    purge |=> (!dma_req && !irq_req && len_level == '0));
endmodule

// File: tb/sim_rx_frame_fifo.sv
module sim_rx_frame_fifo;
  logic        clk = 1'b0;
  logic        rst, purge, wr_en, eof_en, rd_en, len_rd_en;
  logic [7:0]  wr_char, rd_char;
  logic [3:0]  wr_stat, rd_stat;
  logic [15:0] eof_len, len_out;
  logic        rd_uf, len_uf, dma_req, irq_req, char_ovr, len_ovr;
  logic [5:0]  dma_thresh, irq_thresh, level;
  logic [2:0]  len_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_frame_fifo u0 (
    .clk(clk), .rst(rst), .purge(purge), .wr_en(wr_en), .wr_char(wr_char),
    .wr_stat(wr_stat), .eof_en(eof_en), .eof_len(eof_len), .rd_en(rd_en),
    .rd_char(rd_char), .rd_stat(rd_stat), .rd_uf(rd_uf), .len_rd_en(len_rd_en),
    .len_out(len_out), .len_uf(len_uf), .dma_thresh(dma_thresh),
    .irq_thresh(irq_thresh), .level(level), .len_level(len_level),
    .dma_req(dma_req), .irq_req(irq_req), .char_ovr(char_ovr), .len_ovr(len_ovr)
  );

  // [20] read op, [19:12] char, [11:8] status, [5:0] level after the op
  localparam logic [23:0] VEC [8] = '{
    24'h0A5101, 24'h03C202, 24'h0FFF03, 24'h1A5102,
    24'h000803, 24'h13C202, 24'h1FFF01, 24'h100800
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    purge = 0; wr_en = 0; eof_en = 0; rd_en = 0; len_rd_en = 0;
  endtask

  task automatic put(input logic [7:0] c, input logic [3:0] s);
    wr_en = 1; wr_char = c; wr_stat = s; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1; purge = 0; wr_en = 0; eof_en = 0; rd_en = 0; len_rd_en = 0;
    wr_char = 0; wr_stat = 0; eof_len = 0; dma_thresh = 6'd63; irq_thresh = 6'd63;
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    // R8 reset state
    check("R8 level", level, 0);
    check("R8 len_level", len_level, 0);
    check("R8 flags", {char_ovr, len_ovr, rd_uf, len_uf, dma_req, irq_req}, 0);
    check("R8 outputs", {rd_char, rd_stat, len_out}, 0);

    // R1 / R9 vector walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][20]) rd_en = 1;
      else begin wr_en = 1; wr_char = VEC[i][19:12]; wr_stat = VEC[i][11:8]; end
      step();
      check("R1 level", level, int'(VEC[i][5:0]));
      if (VEC[i][20]) begin
        check("R1 char", rd_char, int'(VEC[i][19:12]));
        check("R1 stat", rd_stat, int'(VEC[i][11:8]));
        check("R3 uf clear", rd_uf, 0);
      end
    end

    // R4 threshold crossing while filling, R2 capacity and overrun
    dma_thresh = 6'd16;
    for (int i = 0; i < 32; i++) begin
      put(8'(i), 4'(i));
      if (i == 14) check("R4 below thr", dma_req, 0);
      if (i == 15) check("R4 at thr", dma_req, 1);
    end
    check("R2 full level", level, 32);
    check("R2 no ovr yet", char_ovr, 0);
    put(8'hEE, 4'hE);
    check("R2 level held", level, 32);
    check("R2 ovr set", char_ovr, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
        rd_en = 1; step();
        if (rd_char != 8'(i) || rd_stat != 4'(i)) bad++;
        if (i == 16) check("R4 drop at 15", dma_req, 0);
        if (i == 15) check("R4 still at 16", dma_req, 1);
      end
      check("R2 drained in order no intruder", bad, 0);
    end
    check("R2 ovr sticky", char_ovr, 1);
    // R9 hold after last read
    step();
    check("R9 hold char", rd_char, 31);
    // R3 empty read
    rd_en = 1; step();
    check("R3 char zero", rd_char, 0);
    check("R3 stat zero", rd_stat, 0);
    check("R3 uf", rd_uf, 1);
    check("R3 level", level, 0);

    // R5 / R6 length queue and interrupt
    irq_thresh = 6'd4; dma_thresh = 6'd63;
    put(8'h01, 0); put(8'h02, 0); put(8'h03, 0);
    check("R5 below thr", irq_req, 0);
    eof_en = 1; eof_len = 16'd3; step();
    check("R5 frame pending", irq_req, 1);
    check("R6 len level", len_level, 1);
    eof_en = 1; eof_len = 16'd100; step();
    eof_en = 1; eof_len = 16'd200; step();
    eof_en = 1; eof_len = 16'd300; step();
    check("R6 len full", len_level, 4);
    eof_en = 1; eof_len = 16'd999; step();
    check("R6 len held", len_level, 4);
    check("R6 len ovr", len_ovr, 1);
    len_rd_en = 1; step(); check("R6 pop0", len_out, 3);
    len_rd_en = 1; step(); check("R6 pop1", len_out, 100);
    len_rd_en = 1; step(); check("R6 pop2", len_out, 200);
    len_rd_en = 1; step(); check("R6 pop3", len_out, 300);
    check("R5 irq off", irq_req, 0);
    len_rd_en = 1; step();
    check("R6 empty pop", len_out, 0);
    check("R6 len uf", len_uf, 1);
    put(8'h04, 0);
    check("R5 level at thr", irq_req, 1);

    // R7 purge with simultaneous write and frame end
    purge = 1; wr_en = 1; wr_char = 8'h77; eof_en = 1; step();
    check("R7 level", level, 0);
    check("R7 len level", len_level, 0);
    check("R7 flags", {char_ovr, len_ovr, dma_req, irq_req}, 0);
    rd_en = 1; step();
    check("R7 write dropped", rd_uf, 1);

    // R10 simultaneous write and read
    put(8'h11, 4'h1); put(8'h22, 4'h2);
    wr_en = 1; wr_char = 8'h33; wr_stat = 4'h3; rd_en = 1; step();
    check("R10 level", level, 2);
    check("R10 char", rd_char, 8'h11);
    step();
    check("R9 held", rd_char, 8'h11);

    finish_run();
  end
endmodule